// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU

This block is a combinational arithmetic/logic unit for a W-bit datapath (32 bits by default). It is assembled from identical one-bit slices. Every slice forms the AND, the OR and the full-adder sum of its two operand bits at the same time. A small per-slice selector then passes one of these onto the result bit, under a two-bit operation code that all slices share.

The adder carry runs from slice to slice. The external carry-in feeds slice 0, and the carry leaving the top slice is reported as the unit's carry-out. Supporting another operation only means adding one more selector input in the slice.

The unit holds no state and has no clock. A new set of operands and an operation code gives a settled result in the same cycle. Surrounding pipeline registers sample that result.

Top module: `rippling_alu`

## Requirements
- R1: With `op_sel_i` = 2'b00 the result is the bitwise AND of `opa_i` and `opb_i`.
- R2: With `op_sel_i` = 2'b01 the result is the bitwise OR of `opa_i` and `opb_i`.
- R3: With `op_sel_i` = 2'b10 the concatenation {`carry_o`, `result_o`} equals `opa_i` + `opb_i` + `carry_i`, taken as an unsigned sum one bit wider than the operands.
- R4: With `op_sel_i` = 2'b11 (reserved) the result is all zeros.
- R5: `carry_o` is the carry leaving the most significant slice for every operation code. It always equals the top carry of `opa_i` + `opb_i` + `carry_i`, even when the result shows a logic operation.
- R6: `carry_i` has no effect on `result_o` under the AND, OR and reserved codes.
- R7: The carry into slice i+1 is the majority of operand bit a[i], operand bit b[i] and the carry into slice i. A carry injected at slice 0 therefore ripples through the full width, so all-ones + 0 + 1 gives a zero result and a carry-out of 1.
- R8: The unit is combinational. Outputs follow a change of inputs within the same cycle, with no clock and no stored state. All-zero inputs give a zero result and a zero carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| op_sel_i | input | 2 | Operation code: 00 AND, 01 OR, 10 add, 11 reserved (zero) |
| carry_i | input | 1 | Carry into slice 0 |
| result_o | output | WIDTH | Selected result word |
| carry_o | output | 1 | Carry out of the most significant slice |

## Verification
Immediate assertions in the bound checker re-evaluate on every input change:
- the result under each of the four operation codes;
- the carry-out against an independent wide sum;
- each link of the internal carry chain against the majority rule.

Only the bench's scenarios can show two things. The first is that toggling the carry-in leaves the logic results untouched: the bench places paired vectors that differ in that bit alone back to back and compares both outcomes. The second is the all-zero input state and the full-length carry ripple from slice 0 to the top, which the bench drives as directed vectors.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned ALU_WIDTH_DEF = 32;
  localparam int unsigned ALU_OP_BITS   = 2;

  typedef enum logic [ALU_OP_BITS-1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_ADD  = 2'b10,
    OP_ZERO = 2'b11
  } alu_op_e;

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);

  // Sum is odd parity of the three inputs; carry is their majority.
  assign s_o  = x_i ^ y_i ^ ci_i;
  assign co_o = (x_i & y_i) | (x_i & ci_i) | (y_i & ci_i);

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    c_i,
  input  alu_op_e op_i,
  output logic    y_o,
  output logic    c_o
);

  logic and_bit;
  logic or_bit;
  logic sum_bit;

  // All candidate results are formed in parallel.
  assign and_bit = a_i & b_i;
  assign or_bit  = a_i | b_i;

  alu_full_adder u_fa (
    .x_i  (a_i),
    .y_i  (b_i),
    .ci_i (c_i),
    .s_o  (sum_bit),
    .co_o (c_o)
  );

  // Per-slice selector: one input per supported operation.
  always_comb begin
    unique case (op_i)
      OP_AND:  y_o = and_bit;
      OP_OR:   y_o = or_bit;
      OP_ADD:  y_o = sum_bit;
      default: y_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rippling_alu.sv
module rippling_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_WIDTH_DEF
) (
  input  logic [WIDTH-1:0]       opa_i,
  input  logic [WIDTH-1:0]       opb_i,
  input  logic [ALU_OP_BITS-1:0] op_sel_i,
  input  logic                   carry_i,
  output logic [WIDTH-1:0]       result_o,
  output logic                   carry_o
);

  localparam int unsigned CHAIN_LEN = WIDTH + 1;

  alu_op_e              op_q;
  logic [CHAIN_LEN-1:0] chain;

  assign op_q     = alu_op_e'(op_sel_i);
  assign chain[0] = carry_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i  (opa_i[i]),
      .b_i  (opb_i[i]),
      .c_i  (chain[i]),
      .op_i (op_q),
      .y_o  (result_o[i]),
      .c_o  (chain[i+1])
    );
  end

  assign carry_o = chain[WIDTH];

endmodule

// File: rtl/rippling_alu_chk.sv
module rippling_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [1:0]       op_sel_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic [WIDTH:0]   chain
);

  logic [WIDTH:0] wide_sum;
  assign wide_sum = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    if (op_sel_i == 2'b00) begin
      p_and_word_r1: assert (result_o == (opa_i & opb_i))
        else $error("R1 AND result mismatch");
    end
    if (op_sel_i == 2'b01) begin
      p_or_word_r2: assert (result_o == (opa_i | opb_i))
        else $error("R2 OR result mismatch");
    end
    if (op_sel_i == 2'b10) begin
      p_add_word_r3: assert ({carry_o, result_o} == wide_sum)
        else $error("R3 sum mismatch");
    end
    if (op_sel_i == 2'b11) begin
      p_reserved_zero_r4: assert (result_o == '0)
        else $error("R4 reserved code not zero");
    end
    p_carry_any_op_r5: assert (carry_o == wide_sum[WIDTH])
      else $error("R5 carry-out mismatch");
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      p_chain_link_r7: assert (chain[i+1] ==
          ((opa_i[i] & opb_i[i]) | (opa_i[i] & chain[i]) | (opb_i[i] & chain[i])))
        else $error("R7 carry link %0d wrong", i);
    end
  end

endmodule

bind rippling_alu rippling_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .op_sel_i (op_sel_i),
  .carry_i  (carry_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .chain    (chain)
);

// File: tb/rippling_alu_bench.sv
`timescale 1ns/1ps
module rippling_alu_bench;

  localparam int unsigned W = 32;
  localparam int unsigned WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [1:0]   op = 2'b00;
  logic         cin = 1'b0;
  logic [W-1:0] res;
  logic         cout;

  always #5 clk = ~clk;

  rippling_alu #(.WIDTH(W)) u_rippling_alu (
    .opa_i    (a),
    .opb_i    (b),
    .op_sel_i (op),
    .carry_i  (cin),
    .result_o (res),
    .carry_o  (cout)
  );

  typedef struct {
    logic [W-1:0] exp_res;
    logic         exp_cout;
    string        tag;
  } item_t;

  item_t sb_q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    done   = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Model built from the requirements.
  function automatic item_t model(input logic [W-1:0] xa, input logic [W-1:0] xb,
                                  input logic [1:0] xop, input logic xc, input string t);
    item_t  it;
    logic [W:0] s;
    s = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
    case (xop)
      2'b00:   it.exp_res = xa & xb;
      2'b01:   it.exp_res = xa | xb;
      2'b10:   it.exp_res = s[W-1:0];
      default: it.exp_res = '0;
    endcase
    it.exp_cout = s[W];
    it.tag      = t;
    return it;
  endfunction

  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic [1:0] xop, input logic xc, input string t);
    @(negedge clk);
    a = xa; b = xb; op = xop; cin = xc;
    sb_q.push_back(model(xa, xb, xop, xc, t));
  endtask

  // Monitor: sample half a cycle after the inputs were driven.
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if (res !== it.exp_res || cout !== it.exp_cout) begin
        n_fail++;
        $display("FAIL %s op=%b a=%h b=%h cin=%b actual res=%h cout=%b expected res=%h cout=%b",
                 it.tag, op, a, b, cin, res, cout, it.exp_res, it.exp_cout);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: zero inputs while in reset give zero outputs.
    drive('0, '0, 2'b00, 1'b0, "R8 zero inputs");
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // R1 / R2 basic patterns
    drive(32'hF0F0_F0F0, 32'hFF00_FF00, 2'b00, 1'b0, "R1 and");
    drive(32'hFFFF_FFFF, 32'h1234_5678, 2'b00, 1'b1, "R1 and mask");
    drive(32'hF0F0_F0F0, 32'h0F0F_0000, 2'b01, 1'b0, "R2 or");
    drive(32'h0000_0000, 32'h8000_0001, 2'b01, 1'b1, "R2 or edge bits");

    // R3 additions
    drive(32'd7, 32'd5, 2'b10, 1'b0, "R3 add small");
    drive(32'd7, 32'd5, 2'b10, 1'b1, "R3 add with cin");
    drive(32'h8000_0000, 32'h8000_0000, 2'b10, 1'b0, "R3 add top carry");

    // R4 reserved
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b11, 1'b1, "R4 reserved zero");

    // R5: carry-out under logic ops reflects the sum's carry
    drive(32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 1'b0, "R5 cout under and");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 2'b01, 1'b0, "R5 cout under or");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 2'b11, 1'b0, "R5 cout under reserved");

    // R6: carry-in toggled alone, logic results unchanged
    for (int k = 0; k < 3; k++) begin
      logic [1:0] o;
      o = (k == 2) ? 2'b11 : 2'(k);
      drive(32'hA5A5_5A5A, 32'h3C3C_C3C3, o, 1'b0, "R6 cin=0");
      drive(32'hA5A5_5A5A, 32'h3C3C_C3C3, o, 1'b1, "R6 cin=1");
    end

    // R7: full-length ripple from slice 0
    drive(32'hFFFF_FFFF, 32'h0000_0000, 2'b10, 1'b1, "R7 full ripple");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 2'b10, 1'b1, "R7 alternating ripple");
    drive(32'h7FFF_FFFF, 32'h0000_0000, 2'b10, 1'b1, "R7 ripple to msb");

    // R8: back-to-back changes settle within the cycle
    drive(32'h0000_FFFF, 32'h0000_0001, 2'b10, 1'b0, "R8 follow 1");
    drive(32'h0000_FFFF, 32'h0000_0001, 2'b00, 1'b0, "R8 follow 2");

    // Pseudo-random sweep over all codes
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] ra, rb;
      rng = next_rng(rng); ra = rng;
      rng = next_rng(rng); rb = rng;
      rng = next_rng(rng);
      case (rng[1:0])
        2'b00:   drive(ra, rb, 2'b00, rng[2], "R1 random");
        2'b01:   drive(ra, rb, 2'b01, rng[2], "R2 random");
        2'b10:   drive(ra, rb, 2'b10, rng[2], "R3 random");
        default: drive(ra, rb, 2'b11, rng[2], "R4 random");
      endcase
    end

    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule